// File: doc/BRIEF.md
# Byte Sign-Extension Execution Unit

This unit executes one register-to-register instruction that takes the least significant byte of a general-purpose register and widens it to a full register value by replicating the byte's top bit. Each cycle it may accept one 32-bit instruction word. It decodes the word and exposes the source register index on a combinational read port. It then registers the widened result together with a write enable and the destination index. When the word's record bit is set, it also produces a four-bit condition field.

The decoder accepts one exact encoding: a primary opcode of 31 and a ten-bit extended opcode of 954. Any other valid word raises a single-cycle illegal flag, and no register or condition write takes place. A mode input selects a 32-bit compatibility view. In that view the byte is widened only to 32 bits, the upper half of the destination is cleared, and the condition compare treats the low word as a signed 32-bit number.

Top module: `sxb_unit`

## Requirements
- R1: A valid word whose bits [31:26] equal 31 and whose bits [10:1] equal 954 produces rfWrEn high on the following cycle for exactly one cycle. The base encoding with the record bit clear is 0x7C000774.
- R2: rsIdx equals word bits [25:21] combinationally. rfWrIdx, registered with the result, equals word bits [20:16].
- R3: Word bits [15:11] have no effect on decode, result or condition field.
- R4: With abi32Mode low, rfWrData[7:0] equals the source's bits [7:0], and rfWrData[63:8] all equal source bit 7.
- R5: With abi32Mode high, rfWrData[31:8] all equal source bit 7 and rfWrData[63:32] are zero.
- R6: With word bit 0 (record) set, crWrEn rises together with rfWrEn. crField is {LT,GT,EQ,SO} in bits [3:0], and exactly one of LT, GT, EQ is set from a signed compare of the result with zero. The compare covers 64 bits, or the low 32 bits in compatibility mode.
- R7: The SO bit of crField equals the xerSo input sampled with the instruction.
- R8: With the record bit clear, crWrEn stays low and crField keeps its previous value.
- R9: A valid non-matching word makes illegal high for one cycle per word, with rfWrEn and crWrEn low and crField unchanged.
- R10: When the source and destination indices are equal, the written value is the widened old content of that register.
- R11: During and right after reset, rfWrEn, crWrEn and illegal are low and crField is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word is present this cycle |
| instrWord | input | 32 | Instruction word |
| abi32Mode | input | 1 | Selects the 32-bit compatibility view |
| xerSo | input | 1 | Current summary-overflow bit |
| rsIdx | output | 5 | Source register read index |
| rsData | input | 64 | Source register read data |
| rfWrEn | output | 1 | Destination register write enable |
| rfWrIdx | output | 5 | Destination register index |
| rfWrData | output | 64 | Widened result |
| crWrEn | output | 1 | Condition field write enable |
| crField | output | 4 | Condition field {LT,GT,EQ,SO} |
| illegal | output | 1 | Decode-miss pulse |

## Verification
The assertions check on every cycle that the upper bits of each written result are copies of the byte's sign in 64-bit mode and zero in compatibility mode. They also check that a condition write carries exactly one of LT, GT, EQ together with the sampled SO bit, that the condition field holds without a write, and that a decode miss never comes with a write. Only the bench's scenarios can show the rest. These are the exact decode boundaries, the ignored RB field, the field positions of the indices, aliasing between source and destination, and the full sweep of all 256 byte values in both modes, with and without the record bit.

// File: rtl/sxb_pkg.sv
package sxb_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;
  localparam int CR_W    = 4;

  // Strobes from decode control to datapath
  typedef struct packed {
    logic wrGpr;
    logic wrCr;
    logic miss;
    logic use32;
  } sxbStrobe_t;

  // Condition field layout, MSB first
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crField_t;
endpackage

// File: rtl/sxb_ctrl.sv
module sxb_ctrl
  import sxb_pkg::*;
#(
  parameter int PRIMARY_OP = 31,
  parameter int EXT_OP     = 954,
  parameter int EN_ABI32   = 1
) (
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               abi32Mode,
  output logic [IDX_W-1:0]   srcIdx,
  output logic [IDX_W-1:0]   dstIdx,
  output sxbStrobe_t         strobe
);
  localparam int PO_W = 6;
  localparam int XO_W = 10;
  localparam int PO_LSB = INSTR_W - PO_W;
  localparam int RS_LSB = PO_LSB - IDX_W;
  localparam int RA_LSB = RS_LSB - IDX_W;
  localparam int XO_LSB = 1;

  logic [PO_W-1:0] primary;
  logic [XO_W-1:0] extOp;
  logic            recBit;
  logic            hit;

  assign primary = instrWord[PO_LSB +: PO_W];
  assign extOp   = instrWord[XO_LSB +: XO_W];
  assign recBit  = instrWord[0];
  assign srcIdx  = instrWord[RS_LSB +: IDX_W];
  assign dstIdx  = instrWord[RA_LSB +: IDX_W];

  // The RB field in the middle of the word is never looked at
  assign hit = (primary == PO_W'(PRIMARY_OP)) && (extOp == XO_W'(EXT_OP));

  always_comb begin
    strobe.wrGpr = instrValid && hit;
    strobe.wrCr  = instrValid && hit && recBit;
    strobe.miss  = instrValid && !hit;
  end

  generate
    if (EN_ABI32 != 0) begin : g_abi32
      assign strobe.use32 = abi32Mode;
    end else begin : g_no_abi32
      assign strobe.use32 = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sxb_dpath.sv
module sxb_dpath
  import sxb_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int SRC_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  sxbStrobe_t       strobe,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic [XLEN-1:0]  srcData,
  input  logic             xerSo,
  output logic             rfWrEn,
  output logic [IDX_W-1:0] rfWrIdx,
  output logic [XLEN-1:0]  rfWrData,
  output logic             crWrEn,
  output logic [CR_W-1:0]  crField,
  output logic             illegal
);
  localparam int HALF = XLEN / 2;

  logic             signBit;
  logic [XLEN-1:0]  wide;
  logic [XLEN-1:0]  narrow;
  logic [XLEN-1:0]  result;
  logic             resNeg;
  logic             resZero;
  crField_t         crNext;

  assign signBit = srcData[SRC_W-1];

  // Full-width and half-width widening, bit by bit
  generate
    for (genvar b = 0; b < XLEN; b++) begin : g_bits
      if (b < SRC_W) begin : g_keep
        assign wide[b]   = srcData[b];
        assign narrow[b] = srcData[b];
      end else if (b < HALF) begin : g_lowfill
        assign wide[b]   = signBit;
        assign narrow[b] = signBit;
      end else begin : g_highfill
        assign wide[b]   = signBit;
        assign narrow[b] = 1'b0;
      end
    end
  endgenerate

  assign result  = strobe.use32 ? narrow : wide;
  assign resNeg  = strobe.use32 ? result[HALF-1] : result[XLEN-1];
  assign resZero = strobe.use32 ? (result[HALF-1:0] == '0) : (result == '0);

  always_comb begin
    crNext.lt = resNeg;
    crNext.gt = !resNeg && !resZero;
    crNext.eq = resZero;
    crNext.so = xerSo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rfWrEn   <= 1'b0;
      rfWrIdx  <= '0;
      rfWrData <= '0;
      crWrEn   <= 1'b0;
      crField  <= '0;
      illegal  <= 1'b0;
    end else begin
      rfWrEn  <= strobe.wrGpr;
      crWrEn  <= strobe.wrCr;
      illegal <= strobe.miss;
      if (strobe.wrGpr) begin
        rfWrIdx  <= dstIdx;
        rfWrData <= result;
      end
      if (strobe.wrCr) begin
        crField <= crNext;
      end
    end
  end
endmodule

// File: rtl/sxb_unit.sv
module sxb_unit
  import sxb_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int SRC_W      = 8,
  parameter int PRIMARY_OP = 31,
  parameter int EXT_OP     = 954,
  parameter int EN_ABI32   = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         instrValid,
  input  logic [31:0]  instrWord,
  input  logic         abi32Mode,
  input  logic         xerSo,
  output logic [4:0]   rsIdx,
  input  logic [XLEN-1:0] rsData,
  output logic         rfWrEn,
  output logic [4:0]   rfWrIdx,
  output logic [XLEN-1:0] rfWrData,
  output logic         crWrEn,
  output logic [3:0]   crField,
  output logic         illegal
);
  sxbStrobe_t       strobe;
  logic [IDX_W-1:0] dstIdx;

  sxb_ctrl #(
    .PRIMARY_OP(PRIMARY_OP),
    .EXT_OP    (EXT_OP),
    .EN_ABI32  (EN_ABI32)
  ) u_ctrl (
    .instrValid(instrValid),
    .instrWord (instrWord),
    .abi32Mode (abi32Mode),
    .srcIdx    (rsIdx),
    .dstIdx    (dstIdx),
    .strobe    (strobe)
  );

  sxb_dpath #(
    .XLEN (XLEN),
    .SRC_W(SRC_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dstIdx  (dstIdx),
    .srcData (rsData),
    .xerSo   (xerSo),
    .rfWrEn  (rfWrEn),
    .rfWrIdx (rfWrIdx),
    .rfWrData(rfWrData),
    .crWrEn  (crWrEn),
    .crField (crField),
    .illegal (illegal)
  );
endmodule

// File: rtl/sxb_chk.sv
module sxb_chk #(
  parameter int XLEN  = 64,
  parameter int SRC_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            instrValid,
  input logic            abi32Mode,
  input logic            xerSo,
  input logic            rfWrEn,
  input logic [XLEN-1:0] rfWrData,
  input logic            crWrEn,
  input logic [3:0]      crField,
  input logic            illegal
);
  localparam int HALF = XLEN / 2;

  // R1: a write only follows an offered word
  a_r1_write_needs_word: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> $past(instrValid));

  // R4: 64-bit mode fills upper bits with the byte sign
  a_r4_sign_fill: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && !$past(abi32Mode)) |->
      ((rfWrData[XLEN-1:SRC_W-1] == '0) || (&rfWrData[XLEN-1:SRC_W-1])));

  // R5: compatibility mode clears upper half
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && $past(abi32Mode)) |-> (rfWrData[XLEN-1:HALF] == '0));

  // R6: condition write carries exactly one relation bit and comes with a GPR write
  a_r6_onehot_rel: assert property (@(posedge clk) disable iff (!rstN)
    crWrEn |-> ($countones(crField[3:1]) == 1 && rfWrEn));

  // R7: SO copies sampled summary overflow
  a_r7_so_copy: assert property (@(posedge clk) disable iff (!rstN)
    crWrEn |-> (crField[0] == $past(xerSo)));

  // R8: field holds without a condition write
  a_r8_cr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !crWrEn |-> $stable(crField));

  // R9: decode miss suppresses all writes
  a_r9_miss_no_write: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!rfWrEn && !crWrEn));
endmodule

bind sxb_unit sxb_chk #(.XLEN(XLEN), .SRC_W(SRC_W)) u_sxb_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instrValid(instrValid),
  .abi32Mode (abi32Mode),
  .xerSo     (xerSo),
  .rfWrEn    (rfWrEn),
  .rfWrData  (rfWrData),
  .crWrEn    (crWrEn),
  .crField   (crField),
  .illegal   (illegal)
);

// File: tb/test_sxb_unit.sv
module test_sxb_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        abi32Mode = 1'b0;
  logic        xerSo = 1'b0;
  logic [4:0]  rsIdx;
  logic [63:0] rsData;
  logic        rfWrEn;
  logic [4:0]  rfWrIdx;
  logic [63:0] rfWrData;
  logic        crWrEn;
  logic [3:0]  crField;
  logic        illegal;

  logic [63:0] regs [32];
  logic [3:0]  crModel = 4'b0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign rsData = regs[rsIdx];

  sxb_unit i_sxb_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .abi32Mode(abi32Mode), .xerSo(xerSo), .rsIdx(rsIdx), .rsData(rsData),
    .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData),
    .crWrEn(crWrEn), .crField(crField), .illegal(illegal)
  );

  function automatic logic [31:0] mkWord(input logic [4:0] rs, input logic [4:0] ra,
                                         input logic [4:0] rb, input logic rc);
    return {6'd31, rs, ra, rb, 10'd954, rc};
  endfunction

  function automatic logic [63:0] refExt(input logic [63:0] v, input logic m32);
    logic [63:0] r;
    r = {{56{v[7]}}, v[7:0]};
    if (m32) r[63:32] = '0;
    return r;
  endfunction

  function automatic logic [3:0] refCr(input logic [63:0] r, input logic m32, input logic so);
    logic neg, zero;
    neg  = m32 ? r[31] : r[63];
    zero = m32 ? (r[31:0] == 0) : (r == 0);
    return {neg, !neg && !zero, zero, so};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one legal word and check its outcome; updates bench register file
  task automatic runLegal(input logic [4:0] rs, input logic [4:0] ra, input logic [4:0] rb,
                          input logic rc, input logic m32, input logic so,
                          input logic [63:0] srcVal);
    logic [63:0] expD;
    logic [3:0]  expC;
    @(negedge clk);
    regs[rs]   = srcVal;
    instrWord  = mkWord(rs, ra, rb, rc);
    instrValid = 1'b1;
    abi32Mode  = m32;
    xerSo      = so;
    #1;
    check("R2 rsIdx", {59'd0, rsIdx}, {59'd0, rs});
    expD = refExt(srcVal, m32);
    expC = rc ? refCr(expD, m32, so) : crModel;
    @(posedge clk);
    #1;
    check("R1 rfWrEn", {63'd0, rfWrEn}, 64'd1);
    check("R2 rfWrIdx", {59'd0, rfWrIdx}, {59'd0, ra});
    check(m32 ? "R5 data" : "R4 data", rfWrData, expD);
    check(rc ? "R6 crWrEn" : "R8 crWrEn", {63'd0, crWrEn}, {63'd0, rc});
    check(rc ? "R6 R7 crField" : "R8 crField", {60'd0, crField}, {60'd0, expC});
    crModel = expC;
    regs[ra] = rfWrData;
    @(negedge clk);
    instrValid = 1'b0;
    @(posedge clk);
    #1;
    check("R1 single pulse", {63'd0, rfWrEn}, 64'd0);
  endtask

  task automatic runBad(input logic [31:0] w);
    @(negedge clk);
    instrWord  = w;
    instrValid = 1'b1;
    xerSo      = 1'b1;
    @(posedge clk);
    #1;
    check("R9 illegal", {63'd0, illegal}, 64'd1);
    check("R9 no writes", {62'd0, rfWrEn, crWrEn}, 64'd0);
    check("R9 cr held", {60'd0, crField}, {60'd0, crModel});
    @(negedge clk);
    instrValid = 1'b0;
    @(posedge clk);
    #1;
    check("R9 one cycle", {63'd0, illegal}, 64'd0);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rnd;
    rnd = $urandom(32'h5EB1);
    for (int i = 0; i < 32; i++) regs[i] = 64'h0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset outputs", {60'd0, rfWrEn, crWrEn, illegal, 1'b0}, 64'd0);
    check("R11 reset cr", {60'd0, crField}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R11 after reset", {61'd0, rfWrEn, crWrEn, illegal}, 64'd0);

    // R1 base encoding constant
    check("R1 base word", {32'd0, mkWord(5'd0, 5'd0, 5'd0, 1'b0)}, 64'h7C000774);

    // R4 R5 R6 R8: full byte sweep, both modes, record on and off
    for (int m = 0; m < 2; m++)
      for (int rc = 0; rc < 2; rc++)
        for (int b = 0; b < 256; b++)
          runLegal(5'($urandom), 5'($urandom), 5'd0, rc[0], m[0], 1'($urandom),
                   {$urandom, $urandom} & 64'hFFFF_FFFF_FFFF_FF00 | 64'(b));

    // R3: RB field changes nothing
    runLegal(5'd4, 5'd9, 5'd31, 1'b1, 1'b0, 1'b0, 64'h1234_5678_9ABC_DE80);
    runLegal(5'd4, 5'd9, 5'd17, 1'b1, 1'b0, 1'b0, 64'h1234_5678_9ABC_DE80);

    // R7: SO set then clear
    runLegal(5'd1, 5'd2, 5'd0, 1'b1, 1'b0, 1'b1, 64'h0);
    runLegal(5'd1, 5'd2, 5'd0, 1'b1, 1'b1, 1'b0, 64'h7F);

    // R10: aliasing, applied twice to same register
    runLegal(5'd3, 5'd3, 5'd0, 1'b0, 1'b0, 1'b0, 64'hAAAA_0000_0000_00F1);
    check("R10 alias", regs[3], 64'hFFFF_FFFF_FFFF_FFF1);
    runLegal(5'd3, 5'd3, 5'd0, 1'b1, 1'b1, 1'b0, regs[3]);
    check("R10 alias 32", regs[3], 64'h0000_0000_FFFF_FFF1);

    // R9: near misses and random words
    runBad(mkWord(5'd1, 5'd2, 5'd0, 1'b1) ^ 32'h0400_0000);
    runBad(mkWord(5'd1, 5'd2, 5'd0, 1'b1) ^ 32'h0000_0002);
    runBad(mkWord(5'd1, 5'd2, 5'd0, 1'b0) ^ 32'h0000_0400);
    runBad({6'd31, 15'd0, 10'd922, 1'b0});
    for (int i = 0; i < 20; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (w[31:26] == 6'd31) w[31:26] = 6'd30;
      runBad(w);
    end

    // Random legal words mixed in
    for (int i = 0; i < 100; i++)
      runLegal(5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), {$urandom, $urandom});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule